// File: doc/BRIEF.md
# Serial Programming Host Sequencer

This block is the host side of an in-system programming link. After its own reset it holds the target's reset line and serial clock low. It then gives the target reset line one positive pulse and waits a long settle time. Next it shifts the fixed 32-bit enable instruction into the target over a synchronous serial link, using SCK, a data line towards the target and a data line back from it. While the third byte of that instruction goes out, the target echoes the second byte. If the echo arrives, the link is in sync and the block accepts 32-bit instructions from a valid/ready command port. It returns each 32-bit word the target shifted back as a one-cycle response.

The serial clock comes from the host clock. Each SCK phase lasts a fixed number of host cycles. That number is the larger of a divider parameter and the smallest count that exceeds two target clock periods. The reset pulse width and the settle delay are also converted from target clocks and microseconds into host cycles. A wrong echo causes a new reset pulse, a new settle wait and a new enable attempt. After a set number of attempts the block stops and reports a sync error.

Top module: `isp_host_seq`

## Requirements
- R1: While `rst_n` is low and right after its release, `tgt_rst`, `tgt_sck`, `tgt_mosi`, `cmd_ready`, `rsp_valid`, `sync_ok` and `sync_err` are all 0.
- R2: Each reset pulse on `tgt_rst` stays high for exactly PULSE_CYC = ceil(RST_TCK*HOST_CLK_HZ/TGT_CLK_HZ)+1 host cycles, and `tgt_sck` is 0 for the whole pulse.
- R3: After every falling edge of `tgt_rst`, at least SETTLE_CYC = (HOST_CLK_HZ/1000000)*SETTLE_US host cycles pass before the next rising edge of `tgt_sck`.
- R4: During an instruction, every SCK high phase lasts exactly HALF host cycles and every low phase lasts at least HALF, where HALF = max(SCK_DIV, floor(2*HOST_CLK_HZ/TGT_CLK_HZ)+1).
- R5: An instruction is 32 SCK rising edges that carry the word most significant bit first, and `tgt_mosi` never changes in the cycle that SCK rises.
- R6: `tgt_miso` is sampled as SCK rises, and the first sampled bit lands in bit 31 of the returned word.
- R7: The enable word is 0xAC530000. Sync is reached when bits [15:8] of its returned word equal 0x53. Then `sync_ok` goes to 1 and `cmd_ready` goes high.
- R8: On an echo mismatch the block pulses `tgt_rst` again, waits the settle time and resends the enable word, for at most MAX_TRIES attempts in all.
- R9: If MAX_TRIES attempts fail, `sync_err` goes to 1 and stays at 1. After that no further reset pulse occurs and `cmd_ready` stays 0.
- R10: A command is accepted when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` then stays 0 until the response. `rsp_valid` is a one-cycle pulse that carries the returned word on `rsp_data`.
- R11: While `sync_ok` is 1, `tgt_rst` is held at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_valid | input | 1 | Instruction offered |
| cmd_ready | output | 1 | Sequencer in sync and idle, can take an instruction |
| cmd_data | input | 32 | Instruction word, most significant byte sent first |
| rsp_valid | output | 1 | One-cycle pulse: returned word valid |
| rsp_data | output | 32 | Word shifted back by the target |
| sync_ok | output | 1 | Enable echo confirmed |
| sync_err | output | 1 | All enable attempts failed |
| tgt_rst | output | 1 | Level driven onto the target's reset pin |
| tgt_sck | output | 1 | Serial clock to the target |
| tgt_mosi | output | 1 | Serial data to the target |
| tgt_miso | input | 1 | Serial data from the target |

## Verification
The retry path is the hardest part to reach, because it needs a target that stays deaf for a chosen number of enable attempts and then answers properly. The bench models the target as a byte echo that counts reset pulses. For the first N attempts it drives its return line constantly high, so the echo byte reads 0xFF. Running the flow with N at zero, one below the attempt limit and at the limit covers first-try sync, late sync and the sync error. In each run the bench counts reset pulses and measures phase widths.

// File: rtl/isp_pkg.sv
package isp_pkg;

  typedef enum logic [2:0] {
    ST_BOOT,
    ST_RST_HI,
    ST_SETTLE,
    ST_ENABLE,
    ST_EN_WAIT,
    ST_IDLE,
    ST_XFER,
    ST_FAIL
  } seq_state_e;

  localparam logic [31:0] PROG_ENABLE_WORD = 32'hAC53_0000;
  localparam logic [7:0]  SYNC_ECHO        = 8'h53;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/isp_sck_gen.sv
module isp_sck_gen #(
  parameter int unsigned HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic phase_end
);
  localparam int unsigned CW = (HALF < 2) ? 1 : $clog2(HALF);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_end;

  assign at_end    = (cnt_q == CW'(HALF - 1));
  assign phase_end = run && at_end;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (at_end) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/isp_shifter.sv
module isp_shifter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] tx_word,
  input  logic         phase_end,
  input  logic         miso,
  output logic         busy,
  output logic         sck,
  output logic         mosi,
  output logic         done,
  output logic [W-1:0] rx_word
);
  localparam int unsigned BW = $clog2(W);

  logic          busy_q, busy_d;
  logic          sck_q, sck_d;
  logic [BW-1:0] bit_q, bit_d;
  logic [W-1:0]  tx_q, tx_d;
  logic [W-1:0]  rx_q, rx_d;
  logic          last_bit;

  assign last_bit = (bit_q == BW'(W - 1));
  assign done     = busy_q && phase_end && sck_q && last_bit;
  assign busy     = busy_q;
  assign sck      = sck_q;
  assign mosi     = busy_q && tx_q[W-1];
  assign rx_word  = rx_q;

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (!busy_q) begin
      if (go) begin
        busy_d = 1'b1;
        sck_d  = 1'b0;
        bit_d  = '0;
        tx_d   = tx_word;
      end
    end else if (phase_end) begin
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[W-2:0], miso};
      end else begin
        sck_d = 1'b0;
        if (last_bit) begin
          busy_d = 1'b0;
        end else begin
          bit_d = bit_q + 1'b1;
          tx_d  = {tx_q[W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      busy_q <= busy_d;
      sck_q  <= sck_d;
      bit_q  <= bit_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end
endmodule

// File: rtl/isp_seq_ctrl.sv
module isp_seq_ctrl
  import isp_pkg::*;
#(
  parameter int unsigned PULSE_CYC  = 9,
  parameter int unsigned SETTLE_CYC = 100,
  parameter int unsigned MAX_TRIES  = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [31:0] cmd_data,
  input  logic        done,
  input  logic [31:0] rx_word,
  output logic        go,
  output logic [31:0] tx_word,
  output logic        tgt_rst,
  output logic        cmd_ready,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        sync_ok,
  output logic        sync_err
);
  localparam int unsigned TMAX = max_u(PULSE_CYC, SETTLE_CYC);
  localparam int unsigned TW   = $clog2(TMAX + 1);
  localparam int unsigned RW   = $clog2(MAX_TRIES + 1);

  seq_state_e  state_q, state_d;
  logic [TW-1:0] timer_q, timer_d;
  logic [RW-1:0] tries_q, tries_d;
  logic          rspv_q, rspv_d;
  logic [31:0]   rsp_q, rsp_d;
  logic          echo_hit;

  assign echo_hit  = (rx_word[15:8] == SYNC_ECHO);
  assign go        = (state_q == ST_ENABLE) || ((state_q == ST_IDLE) && cmd_valid);
  assign tx_word   = (state_q == ST_ENABLE) ? PROG_ENABLE_WORD : cmd_data;
  assign tgt_rst   = (state_q == ST_RST_HI);
  assign cmd_ready = (state_q == ST_IDLE);
  assign sync_ok   = (state_q == ST_IDLE) || (state_q == ST_XFER);
  assign sync_err  = (state_q == ST_FAIL);
  assign rsp_valid = rspv_q;
  assign rsp_data  = rsp_q;

  always_comb begin
    state_d = state_q;
    timer_d = timer_q;
    tries_d = tries_q;
    rspv_d  = 1'b0;
    rsp_d   = rsp_q;
    case (state_q)
      ST_BOOT: begin
        if (timer_q == TW'(PULSE_CYC - 1)) begin
          state_d = ST_RST_HI;
          timer_d = '0;
        end else timer_d = timer_q + 1'b1;
      end
      ST_RST_HI: begin
        if (timer_q == TW'(PULSE_CYC - 1)) begin
          state_d = ST_SETTLE;
          timer_d = '0;
        end else timer_d = timer_q + 1'b1;
      end
      ST_SETTLE: begin
        if (timer_q == TW'(SETTLE_CYC - 1)) begin
          state_d = ST_ENABLE;
          timer_d = '0;
        end else timer_d = timer_q + 1'b1;
      end
      ST_ENABLE:  state_d = ST_EN_WAIT;
      ST_EN_WAIT: begin
        if (done) begin
          if (echo_hit) begin
            state_d = ST_IDLE;
          end else if (tries_q == RW'(MAX_TRIES - 1)) begin
            state_d = ST_FAIL;
          end else begin
            tries_d = tries_q + 1'b1;
            state_d = ST_RST_HI;
            timer_d = '0;
          end
        end
      end
      ST_IDLE: begin
        if (cmd_valid) state_d = ST_XFER;
      end
      ST_XFER: begin
        if (done) begin
          rspv_d  = 1'b1;
          rsp_d   = rx_word;
          state_d = ST_IDLE;
        end
      end
      ST_FAIL: state_d = ST_FAIL;
      default: state_d = ST_FAIL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_BOOT;
      timer_q <= '0;
      tries_q <= '0;
      rspv_q  <= 1'b0;
      rsp_q   <= '0;
    end else begin
      state_q <= state_d;
      timer_q <= timer_d;
      tries_q <= tries_d;
      rspv_q  <= rspv_d;
      rsp_q   <= rsp_d;
    end
  end
endmodule

// File: rtl/isp_host_seq.sv
module isp_host_seq
  import isp_pkg::*;
#(
  parameter int unsigned HOST_CLK_HZ = 100_000_000,
  parameter int unsigned TGT_CLK_HZ  = 4_000_000,
  parameter int unsigned SCK_DIV     = 4,
  parameter int unsigned RST_TCK     = 2,
  parameter int unsigned SETTLE_US   = 20_000,
  parameter int unsigned MAX_TRIES   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [31:0] cmd_data,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        sync_ok,
  output logic        sync_err,
  output logic        tgt_rst,
  output logic        tgt_sck,
  output logic        tgt_mosi,
  input  logic        tgt_miso
);
  localparam int unsigned MIN_HALF   = (2 * HOST_CLK_HZ) / TGT_CLK_HZ + 1;
  localparam int unsigned SCK_HALF   = max_u(SCK_DIV, MIN_HALF);
  localparam int unsigned PULSE_CYC  = ceil_div(RST_TCK * HOST_CLK_HZ, TGT_CLK_HZ) + 1;
  localparam int unsigned SETTLE_CYC = (HOST_CLK_HZ / 1_000_000) * SETTLE_US;

  logic        go, busy, phase_end, done;
  logic [31:0] tx_word, rx_word;

  isp_sck_gen #(.HALF(SCK_HALF)) u_sck (
    .clk(clk), .rst_n(rst_n), .run(busy), .phase_end(phase_end)
  );

  isp_shifter #(.W(32)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(go), .tx_word(tx_word),
    .phase_end(phase_end), .miso(tgt_miso), .busy(busy),
    .sck(tgt_sck), .mosi(tgt_mosi), .done(done), .rx_word(rx_word)
  );

  isp_seq_ctrl #(
    .PULSE_CYC(PULSE_CYC), .SETTLE_CYC(SETTLE_CYC), .MAX_TRIES(MAX_TRIES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .done(done), .rx_word(rx_word), .go(go), .tx_word(tx_word),
    .tgt_rst(tgt_rst), .cmd_ready(cmd_ready), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .sync_ok(sync_ok), .sync_err(sync_err)
  );
endmodule

// File: rtl/isp_host_seq_chk.sv
module isp_host_seq_chk #(
  parameter int unsigned HALF = 4
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic cmd_ready,
  input logic rsp_valid,
  input logic sync_ok,
  input logic sync_err,
  input logic tgt_rst,
  input logic tgt_sck,
  input logic tgt_mosi
);
  logic [31:0] hi_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_len <= '0;
    else if (tgt_sck) hi_len <= hi_len + 1'b1;
    else              hi_len <= '0;
  end

  p_rst_sck_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_rst |-> !tgt_sck);
  p_high_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_sck) |-> (hi_len == HALF));
  p_mosi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_sck) |-> $stable(tgt_mosi));
  p_ready_needs_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> sync_ok);
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> (sync_err && !sync_ok && !tgt_rst));
  p_accept_drops_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  p_rsp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  p_rst_low_synced_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ok |-> !tgt_rst);
endmodule

bind isp_host_seq isp_host_seq_chk #(.HALF(SCK_HALF)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .sync_ok(sync_ok), .sync_err(sync_err),
  .tgt_rst(tgt_rst), .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi)
);

// File: tb/isp_host_seq_bench.sv
`timescale 1ns/1ps
module isp_host_seq_bench;
  localparam int unsigned HOST = 100_000_000;
  localparam int unsigned TGT  = 25_000_000;
  localparam int unsigned DIV  = 12;
  localparam int unsigned RTCK = 2;
  localparam int unsigned SUS  = 1;
  localparam int unsigned TRY  = 3;

  localparam int unsigned MINH   = (2 * HOST) / TGT + 1;
  localparam int unsigned HALF   = (DIV > MINH) ? DIV : MINH;
  localparam int unsigned PULSE  = (RTCK * HOST + TGT - 1) / TGT + 1;
  localparam int unsigned SETTLE = (HOST / 1_000_000) * SUS;

  logic        clk, rst_n;
  logic        cmd_valid, cmd_ready, rsp_valid, sync_ok, sync_err;
  logic [31:0] cmd_data, rsp_data;
  logic        tgt_rst, tgt_sck, tgt_mosi, tgt_miso;

  int checks, failures;
  bit finished;

  isp_host_seq #(
    .HOST_CLK_HZ(HOST), .TGT_CLK_HZ(TGT), .SCK_DIV(DIV),
    .RST_TCK(RTCK), .SETTLE_US(SUS), .MAX_TRIES(TRY)
  ) u_isp_host_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .sync_ok(sync_ok), .sync_err(sync_err), .tgt_rst(tgt_rst),
    .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi), .tgt_miso(tgt_miso)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // ---------------- target model: byte echo, deaf for first fail_n attempts
  int          fail_n;
  int          attempts;
  int          rises;
  logic [2:0]  bitn;
  logic [7:0]  byte_sh, last_byte;
  logic [31:0] tgt_rx;

  always @(posedge tgt_sck or posedge tgt_rst or negedge rst_n) begin
    if (!rst_n) begin
      attempts = 0; rises = 0; bitn = 3'd0; byte_sh = 8'h00; last_byte = 8'h00; tgt_rx = 32'h0;
    end else if (tgt_rst) begin
      attempts = attempts + 1; bitn = 3'd0; last_byte = 8'h00;
    end else begin
      tgt_rx  = {tgt_rx[30:0], tgt_mosi};
      byte_sh = {byte_sh[6:0], tgt_mosi};
      rises   = rises + 1;
      if (bitn == 3'd7) last_byte = byte_sh;
      bitn = bitn + 3'd1;
    end
  end

  always @(negedge tgt_sck or negedge tgt_rst or negedge rst_n) begin
    if (!rst_n) tgt_miso = 1'b0;
    else if (attempts <= fail_n) tgt_miso = 1'b1;
    else tgt_miso = last_byte[3'd7 - bitn];
  end

  // ---------------- port monitors, sampled away from the active edge
  int  rst_hi, last_pulse, pulse_cnt;
  int  settle_cnt, min_settle;
  bit  settle_arm;
  int  sck_hi, sck_lo, phase_err, low_exact;
  int  mosi_err;
  logic p_rst, p_sck, p_mosi;

  always @(negedge clk) begin
    if (!rst_n) begin
      rst_hi = 0; last_pulse = 0; pulse_cnt = 0; settle_cnt = 0; min_settle = 1 << 30;
      settle_arm = 0; sck_hi = 0; sck_lo = 0; p_rst = 0; p_sck = 0; p_mosi = 0;
    end else begin
      if (tgt_rst) begin
        rst_hi++;
        if (tgt_sck) phase_err++;
      end else if (p_rst) begin
        last_pulse = rst_hi; rst_hi = 0; pulse_cnt++;
        settle_arm = 1; settle_cnt = 0;
      end
      if (tgt_sck && !p_sck) begin
        if (settle_arm) begin
          if (settle_cnt < min_settle) min_settle = settle_cnt;
          settle_arm = 0;
        end
        if (sck_lo < HALF) phase_err++;
        if (sck_lo == HALF) low_exact++;
        if (tgt_mosi !== p_mosi) mosi_err++;
        sck_lo = 0;
      end
      if (!tgt_sck && p_sck) begin
        if (sck_hi != HALF) phase_err++;
        sck_hi = 0;
      end
      if (tgt_sck) sck_hi++;
      else if (!tgt_rst) sck_lo++;
      if (settle_arm && !tgt_sck && !tgt_rst) settle_cnt++;
      p_rst = tgt_rst; p_sck = tgt_sck; p_mosi = tgt_mosi;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [31:0] word, input logic [7:0] prev_last);
    int r0;
    int w;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_data = word;
    while (!cmd_ready) @(negedge clk);
    r0 = rises;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_ready == 1'b0, "R10 ready low after accept", 32'(cmd_ready), 32'h0);
    w = 0;
    while (!rsp_valid && w < 5000) begin @(negedge clk); w++; end
    chk(rsp_data == {prev_last, word[31:8]}, "R6 returned word", rsp_data, {prev_last, word[31:8]});
    chk(tgt_rx == word, "R5 word seen by target", tgt_rx, word);
    chk(rises - r0 == 32, "R5 rising edges per instruction", 32'(rises - r0), 32'd32);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R10 response pulse width", 32'(rsp_valid), 32'h0);
  endtask

  task automatic scenario(input int deaf);
    int w;
    int exp_p;
    logic [7:0] prev;
    fail_n = deaf;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0;
    repeat (4) @(negedge clk);
    chk({tgt_rst, tgt_sck, tgt_mosi, cmd_ready, rsp_valid, sync_ok, sync_err} == 7'b0,
        "R1 outputs in reset", 32'({tgt_rst, tgt_sck, tgt_mosi, cmd_ready, rsp_valid, sync_ok, sync_err}), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({tgt_rst, tgt_sck, cmd_ready, sync_ok, sync_err} == 5'b0,
        "R1 outputs after release", 32'({tgt_rst, tgt_sck, cmd_ready, sync_ok, sync_err}), 32'h0);
    w = 0;
    while (!sync_ok && !sync_err && w < 20000) begin @(negedge clk); w++; end
    exp_p = (deaf + 1 < TRY) ? deaf + 1 : TRY;
    chk(last_pulse == PULSE, "R2 reset pulse width", 32'(last_pulse), 32'(PULSE));
    chk(min_settle >= SETTLE, "R3 settle before SCK", 32'(min_settle), 32'(SETTLE));
    chk(pulse_cnt == exp_p, "R8 reset pulses per attempt", 32'(pulse_cnt), 32'(exp_p));
    if (deaf < TRY) begin
      chk(sync_ok && !sync_err, "R7 sync reached", 32'({sync_ok, sync_err}), 32'h2);
      chk(cmd_ready && !tgt_rst, "R11 ready with reset low", 32'({cmd_ready, tgt_rst}), 32'h2);
      prev = 8'h00;
      for (int i = 0; i < 8; i++) begin
        logic [31:0] word;
        word = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : 32'h1357_9BDF * 32'(i) ^ (32'h1 << i);
        run_cmd(word, prev);
        prev = word[7:0];
      end
      chk(!tgt_rst && sync_ok, "R11 reset held low in session", 32'(tgt_rst), 32'h0);
    end else begin
      repeat (300) @(negedge clk);
      chk(sync_err && !sync_ok && !cmd_ready, "R9 sync error final", 32'({sync_err, sync_ok, cmd_ready}), 32'h4);
      chk(pulse_cnt == TRY, "R9 no pulse after error", 32'(pulse_cnt), 32'(TRY));
    end
  endtask

  initial begin
    checks = 0; failures = 0; finished = 0; fail_n = 0;
    low_exact = 0; phase_err = 0; mosi_err = 0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_data = '0;
    scenario(0);
    scenario(TRY - 1);
    scenario(TRY);
    chk(phase_err == 0, "R4 SCK phase widths", 32'(phase_err), 32'h0);
    chk(low_exact > 0, "R4 low phase of HALF seen", 32'(low_exact), 32'h1);
    chk(mosi_err == 0, "R5 MOSI stable at rise", 32'(mosi_err), 32'h0);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule